// File: doc/BRIEF.md
# Indirect Access Address Redirector

This block sits on an 8-bit data-address bus between a processor and its data memory. It adds indirect addressing with two fixed bus locations. Location 0x0F holds an index byte, and location 0x0E is a data window. Any read or write of the window is sent to the memory address currently held in the index byte. Reads and writes of 0x0F reach the index byte, which is stored inside the block and never passes to memory. Every other address passes straight through to memory.

The translation is purely combinational. A window access therefore completes in the same cycle as a direct access, and the only state in the block is the index byte. The redirection happens once only: a window access whose index names the window itself goes to memory location 0x0E. A window access whose index names 0x0F reaches the index byte.

Top module: `indirect_redirector`

## Requirements
- R1: For any address other than 0x0E and 0x0F, mem_addr equals cpu_addr, mem_rd and mem_wr follow cpu_rd and cpu_wr, mem_wdata equals cpu_wdata, and cpu_rdata equals mem_rdata, all within the same cycle.
- R2: A write to 0x0F loads cpu_wdata into the index byte at the next rising clock edge, and mem_wr stays low.
- R3: A read of 0x0F returns the index byte on cpu_rdata in the same cycle, and mem_rd stays low.
- R4: A read or write of 0x0E, while the index byte is not 0x0F, drives mem_addr with the index byte and forwards the strobe and the data in the same cycle.
- R5: When the index byte is 0x0E, an access to 0x0E reaches memory location 0x0E and is not redirected a second time.
- R6: When the index byte is 0x0F, an access to 0x0E reads or writes the index byte itself, and neither memory strobe is raised.
- R7: Reset (rst_n low) clears the index byte to 0x00. After reset, a read of 0x0F returns 0x00 and a read of 0x0E addresses memory location 0x00.
- R8: The index byte keeps its value across any cycle without a write that resolves to 0x0F.
- R9: When neither cpu_rd nor cpu_wr is high, both mem_rd and mem_wr are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Processor data address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| mem_addr | output | 8 | Translated memory address |
| mem_wdata | output | 8 | Write data to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Read data from memory |

## Verification
The assertions assume that the processor never raises cpu_rd and cpu_wr in the same cycle. They also assume that every input is stable around the sampling clock edge. The bench drives one strobe at a time, changes inputs only on the falling edge, and drops all strobes between accesses. A combinational memory model answers reads, so each translated address can be observed in the same cycle and read back afterwards.

// File: rtl/irr_pkg.sv
package irr_pkg;
    typedef enum logic {
        TGT_MEM  = 1'b0,
        TGT_XREG = 1'b1
    } target_e;
endpackage

// File: rtl/irr_translate.sv
module irr_translate #(
    parameter int unsigned WIDTH    = 8,
    parameter logic [WIDTH-1:0] WIN_ADDR = 8'h0E,
    parameter logic [WIDTH-1:0] IDX_ADDR = 8'h0F
) (
    input  logic [WIDTH-1:0] cpu_addr,
    input  logic [WIDTH-1:0] x_q,
    output logic [WIDTH-1:0] eff_addr,
    output irr_pkg::target_e target
);
    // single-level redirection: the window substitutes X once, never again
    always_comb begin
        eff_addr = (cpu_addr == WIN_ADDR) ? x_q : cpu_addr;
        target   = (eff_addr == IDX_ADDR) ? irr_pkg::TGT_XREG : irr_pkg::TGT_MEM;
    end
endmodule

// File: rtl/irr_index_reg.sv
module irr_index_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] x_q
);
    typedef struct packed {
        logic [WIDTH-1:0] x;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.x = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_q = st_q.x;

    // R8
    x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (x_q == $past(x_q)));

    // R2
    x_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (x_q == $past(wdata)));
endmodule

// File: rtl/irr_port_mux.sv
module irr_port_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irr_pkg::target_e target,
    input  logic [WIDTH-1:0] eff_addr,
    input  logic [WIDTH-1:0] x_q,
    input  logic [WIDTH-1:0] cpu_wdata,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [WIDTH-1:0] cpu_rdata,
    output logic [WIDTH-1:0] mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             x_we
);
    logic to_mem;

    always_comb begin
        to_mem    = (target == irr_pkg::TGT_MEM);
        mem_addr  = eff_addr;
        mem_wdata = cpu_wdata;
        mem_rd    = cpu_rd && to_mem;
        mem_wr    = cpu_wr && to_mem;
        x_we      = cpu_wr && !to_mem;
        cpu_rdata = to_mem ? mem_rdata : x_q;
    end

    // input assumption: one strobe at a time
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_wr));

    // R9
    mem_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, x_we}));
endmodule

// File: rtl/indirect_redirector.sv
module indirect_redirector #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] WIN_ADDR = 8'h0E,
    parameter logic [WIDTH-1:0] IDX_ADDR = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cpu_addr,
    input  logic [WIDTH-1:0] cpu_wdata,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    output logic [WIDTH-1:0] cpu_rdata,
    output logic [WIDTH-1:0] mem_addr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic             mem_rd,
    output logic             mem_wr,
    input  logic [WIDTH-1:0] mem_rdata
);
    logic [WIDTH-1:0] x_q;
    logic [WIDTH-1:0] eff_addr;
    irr_pkg::target_e target;
    logic             x_we;

    irr_translate #(.WIDTH(WIDTH), .WIN_ADDR(WIN_ADDR), .IDX_ADDR(IDX_ADDR)) u_xlat (
        .cpu_addr (cpu_addr),
        .x_q      (x_q),
        .eff_addr (eff_addr),
        .target   (target)
    );

    irr_index_reg #(.WIDTH(WIDTH)) u_xreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (x_we),
        .wdata (cpu_wdata),
        .x_q   (x_q)
    );

    irr_port_mux #(.WIDTH(WIDTH)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (target),
        .eff_addr  (eff_addr),
        .x_q       (x_q),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .mem_rdata (mem_rdata),
        .cpu_rdata (cpu_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .x_we      (x_we)
    );

    // R1
    pass_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr != WIN_ADDR && cpu_addr != IDX_ADDR)
        |-> (mem_wr && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

    // R3
    xreg_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == IDX_ADDR) |-> (!mem_rd && cpu_rdata == x_q));

    // R4
    win_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr == WIN_ADDR && x_q != IDX_ADDR)
        |-> (mem_addr == x_q && (mem_rd || mem_wr)));

    // R6
    win_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == WIN_ADDR && x_q == IDX_ADDR) |-> (!mem_rd && !mem_wr));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (!mem_rd && !mem_wr));
endmodule

// File: tb/tb_indirect_redirector.sv
`timescale 1ns/1ps
module tb_indirect_redirector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_rdata, mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr;
    logic [7:0] mem [256];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    indirect_redirector dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // apply one access at the falling edge, sample 1 ns later
    task automatic access(input logic [7:0] a, input logic [7:0] d, input bit rd, input bit wr);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        access(8'h0F, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h00, "R7 X after reset", cpu_rdata, 8'h00);
        access(8'h0E, 8'h00, 1, 0);
        chk(mem_addr == 8'h00 && mem_rd, "R7 window after reset", mem_addr, 8'h00);
        idle();
    endtask

    task automatic t_passthru();
        access(8'h40, 8'hA5, 0, 1);
        chk(mem_wr && mem_addr == 8'h40 && mem_wdata == 8'hA5, "R1 direct write", mem_addr, 8'h40);
        idle();
        chk(!mem_rd && !mem_wr, "R9 idle strobes", {mem_rd, mem_wr}, 0);
        access(8'h40, 8'h00, 1, 0);
        chk(mem_rd && cpu_rdata == 8'hA5, "R1 direct read", cpu_rdata, 8'hA5);
        idle();
    endtask

    task automatic t_xreg();
        access(8'h0F, 8'h40, 0, 1);
        chk(!mem_wr, "R2 X write no mem strobe", mem_wr, 0);
        idle();
        access(8'h0F, 8'h00, 1, 0);
        chk(!mem_rd && cpu_rdata == 8'h40, "R3 X read", cpu_rdata, 8'h40);
        idle();
    endtask

    task automatic t_window();
        access(8'h0E, 8'h00, 1, 0);
        chk(mem_rd && mem_addr == 8'h40 && cpu_rdata == 8'hA5, "R4 window read", cpu_rdata, 8'hA5);
        access(8'h0E, 8'h3C, 0, 1);
        chk(mem_wr && mem_addr == 8'h40, "R4 window write addr", mem_addr, 8'h40);
        idle();
        access(8'h40, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h3C, "R4 window write landed", cpu_rdata, 8'h3C);
        idle();
    endtask

    task automatic t_x_is_window();
        access(8'h0F, 8'h0E, 0, 1);
        idle();
        access(8'h0E, 8'h77, 0, 1);
        chk(mem_wr && mem_addr == 8'h0E, "R5 window to 0x0E", mem_addr, 8'h0E);
        idle();
        chk(mem[8'h0E] == 8'h77, "R5 memory 0x0E written", mem[8'h0E], 8'h77);
        access(8'h0F, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h0E, "R8 X kept after window write", cpu_rdata, 8'h0E);
        idle();
    endtask

    task automatic t_x_is_index();
        access(8'h0F, 8'h0F, 0, 1);
        idle();
        access(8'h0E, 8'h00, 1, 0);
        chk(!mem_rd && cpu_rdata == 8'h0F, "R6 window reads X", cpu_rdata, 8'h0F);
        access(8'h0E, 8'h55, 0, 1);
        chk(!mem_wr, "R6 window write no mem strobe", mem_wr, 0);
        idle();
        access(8'h0F, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h55, "R6 window wrote X", cpu_rdata, 8'h55);
        idle();
    endtask

    task automatic t_x_stable();
        access(8'h20, 8'h99, 0, 1);
        idle();
        access(8'h0F, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h55, "R8 X kept after other write", cpu_rdata, 8'h55);
        idle();
        access(8'h20, 8'h00, 1, 0);
        chk(cpu_rdata == 8'h99, "R1 second direct read", cpu_rdata, 8'h99);
        idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_xreg();
        t_window();
        t_x_is_window();
        t_x_is_index();
        t_x_stable();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule